// File: doc/BRIEF.md
# Selectable Pin Interrupt Unit

This block turns a wide bus of general-purpose inputs into eight separate interrupt request lines. Each channel has its own configuration word. The word names the input bit that the channel watches, enables the channel, and picks how the channel senses that input. In edge mode a channel reacts to rising edges, falling edges or both. In level mode it reacts to a high or a low level.

Every input bit first passes through a two-stage synchroniser. A third stage keeps the previous synchronised sample of the whole bus. An edge is therefore seen as a difference between two settled samples of the same bit. Changing a channel's selection cannot create a false edge this way.

Edge events are held in a sticky status bit until software clears them. Level requests follow the synchronised input directly. Software reaches the configuration words and the status word through one address/data port: a write strobe and a combinational read.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset every configuration word reads 0, the status word (address 8) reads 0 and all `irq` lines are low.
- R2: The configuration word of channel i sits at address i (0..7). It holds the input select in bits [5:0], enable in bit 8, level mode in bit 9, and in bit 10 either the rising-edge enable (edge mode) or active-high (level mode). Bit 11 is the falling-edge enable. Any other bits read back as 0.
- R3: An enabled edge channel that sees a rising edge on its selected input, with rising enabled, raises its status bit and `irq` on the third clock edge after the input changes, and not earlier.
- R4: In edge mode a falling edge sets the request only when bit 11 is set, and a rising edge only when bit 10 is set. With both bits set, either edge fires.
- R5: In level mode `irq` follows the synchronised input two clock edges after it changes: the input itself when bit 10 is 1, its inverse when bit 10 is 0. Clear writes have no effect on it.
- R6: Writing address 8 with a 1 in bit i clears status bit i and drops channel i's edge request on the next clock edge. Reading address 8 returns the status bits in bits [7:0].
- R7: If a new edge is detected in the same cycle as a clear of that channel, the status bit stays set.
- R8: Any write to a channel's configuration word clears that channel's status bit.
- R9: A select value of 48 or more (beyond the input bus) reads the input as constant 0.
- R10: A channel whose enable bit is 0 never sets its status bit and never raises `irq`.
- R11: Channels are independent. An edge on one channel's input raises only that channel's line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 48 | Asynchronous general-purpose inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address, shared by read and write |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data (combinational on `addr`) |
| irq | output | 8 | One interrupt request per channel |

## Verification
One channel is driven through each sensing mode with both directions of input change. This separates rising from falling from both-edge sensing, high-active from low-active level, and enabled from disabled channels. Directed sequences then check exact latency, using a level channel's two-edge path against an edge channel's three-edge path. They also place a clear on the exact cycle an edge is detected, to check that the edge wins. Further sequences check an out-of-range select, that a configuration rewrite clears a pending event, and that an edge on one channel leaves a neighbouring channel quiet.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int DATA_W  = 16;
  localparam int F_EN    = 8;
  localparam int F_LVL   = 9;
  localparam int F_RH    = 10;
  localparam int F_FL    = 11;

  // edge request from current and previous synchronised sample
  function automatic logic edge_fire(input logic rise_en, input logic fall_en,
                                     input logic cur, input logic prev);
    return (rise_en & cur & ~prev) | (fall_en & ~cur & prev);
  endfunction

  // level request after polarity adjustment
  function automatic logic level_fire(input logic active_hi, input logic cur);
    return active_hi ? cur : ~cur;
  endfunction
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      cur  <= '0;
      prev <= '0;
    end else begin
      meta <= din;
      cur  <= meta;
      prev <= cur;
    end
  end
endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan
  import pin_irq_pkg::*;
#(
  parameter int GPIO_W = 48,
  parameter int SEL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPIO_W-1:0] cur,
  input  logic [GPIO_W-1:0] prev,
  input  logic [SEL_W-1:0]  sel,
  input  logic              en,
  input  logic              lvl,
  input  logic              rh,
  input  logic              fl,
  input  logic              cfg_wr,
  input  logic              clr,
  output logic              edge_hit,
  output logic              pending,
  output logic              irq
);
  // out-of-range selections read as 0
  function automatic logic pick(input logic [GPIO_W-1:0] v, input logic [SEL_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int k = 0; k < GPIO_W; k++)
      if (s == SEL_W'(k)) r = v[k];
    return r;
  endfunction

  logic pin_cur, pin_prev;

  assign pin_cur  = pick(cur, sel);
  assign pin_prev = pick(prev, sel);
  assign edge_hit = en & ~lvl & edge_fire(rh, fl, pin_cur, pin_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pending <= 1'b0;
    else if (cfg_wr)   pending <= 1'b0;
    else if (edge_hit) pending <= 1'b1;
    else if (clr)      pending <= 1'b0;
  end

  assign irq = en & (lvl ? level_fire(rh, pin_cur) : pending);
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pin_irq_pkg::*;
#(
  parameter int GPIO_W = 48,
  parameter int NCH    = 8,
  parameter int SEL_W  = 6,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPIO_W-1:0] gpio_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCH-1:0]    irq
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NCH);

  logic [GPIO_W-1:0] s_cur, s_prev;
  logic [SEL_W-1:0]  sel_q [NCH];
  logic [NCH-1:0]    en_vec, lvl_vec, rh_vec, fl_vec;
  logic [NCH-1:0]    cfg_wr, clr_vec, edge_hit, pending;

  pin_irq_sync #(.W(GPIO_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(gpio_in), .cur(s_cur), .prev(s_prev)
  );

  assign clr_vec = (wr_en && addr == STAT_ADDR) ? wr_data[NCH-1:0] : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cfg_wr[i] = wr_en && (addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[i]   <= '0;
        en_vec[i]  <= 1'b0;
        lvl_vec[i] <= 1'b0;
        rh_vec[i]  <= 1'b0;
        fl_vec[i]  <= 1'b0;
      end else if (cfg_wr[i]) begin
        sel_q[i]   <= wr_data[SEL_W-1:0];
        en_vec[i]  <= wr_data[F_EN];
        lvl_vec[i] <= wr_data[F_LVL];
        rh_vec[i]  <= wr_data[F_RH];
        fl_vec[i]  <= wr_data[F_FL];
      end
    end

    pin_irq_chan #(.GPIO_W(GPIO_W), .SEL_W(SEL_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .cur(s_cur), .prev(s_prev),
      .sel(sel_q[i]), .en(en_vec[i]), .lvl(lvl_vec[i]),
      .rh(rh_vec[i]), .fl(fl_vec[i]), .cfg_wr(cfg_wr[i]), .clr(clr_vec[i]),
      .edge_hit(edge_hit[i]), .pending(pending[i]), .irq(irq[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NCH; k++) begin
      if (addr == ADDR_W'(k)) begin
        rd_data[SEL_W-1:0] = sel_q[k];
        rd_data[F_EN]      = en_vec[k];
        rd_data[F_LVL]     = lvl_vec[k];
        rd_data[F_RH]      = rh_vec[k];
        rd_data[F_FL]      = fl_vec[k];
      end
    end
    if (addr == STAT_ADDR) rd_data[NCH-1:0] = pending;
  end
endmodule

module pin_irq_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] edge_hit,
  input logic [NCH-1:0] pending,
  input logic [NCH-1:0] cfg_wr,
  input logic [NCH-1:0] clr_vec,
  input logic [NCH-1:0] en_vec
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> (irq == '0));

  a_r7_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_hit & ~cfg_wr) != '0) |=>
      ((pending & $past(edge_hit & ~cfg_wr)) == $past(edge_hit & ~cfg_wr)));

  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~edge_hit) != '0) |=> ((pending & $past(clr_vec & ~edge_hit)) == '0));

  a_r8_cfg_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr != '0) |=> ((pending & $past(cfg_wr)) == '0));

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & ~clr_vec & ~cfg_wr) != '0) |=>
      ((pending & $past(pending & ~clr_vec & ~cfg_wr)) == $past(pending & ~clr_vec & ~cfg_wr)));

  a_r10_off_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & ~en_vec) == '0));
endmodule

bind pin_irq_unit pin_irq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .edge_hit(edge_hit), .pending(pending),
  .cfg_wr(cfg_wr), .clr_vec(clr_vec), .en_vec(en_vec)
);

// File: tb/tb_pin_irq_unit.sv
module tb_pin_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] gpio_in = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [7:0]  irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pin_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  // [11:8] mode flags (en,lvl,rh,fl), [2] expected irq, [1] input before, [0] input after
  localparam logic [15:0] VEC [11] = '{
    16'h0505, 16'h0502, 16'h0906, 16'h0901, 16'h0D05, 16'h0D06,
    16'h0705, 16'h0702, 16'h0306, 16'h0301, 16'h0401
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    tick(3);
    // R1 reset state
    chk("R1 irq", {8'h0, irq}, 16'h0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 irq after release", {8'h0, irq}, 16'h0);
    rd(4'd0, d); chk("R1 cfg0", d, 16'h0);
    rd(4'd8, d); chk("R1 status", d, 16'h0);

    // R2 field layout and read-back
    wr(4'd3, 16'hFFFF);
    rd(4'd3, d); chk("R2 readback", d, 16'h0F3F);
    wr(4'd3, 16'h0000);
    rd(4'd3, d); chk("R2 readback zero", d, 16'h0000);

    // table: channel 0 watching input bit 5 (R3 R4 R5 R10)
    for (int i = 0; i < 11; i++) begin
      gpio_in[5] = VEC[i][1];
      tick(4);
      wr(4'd0, (VEC[i] & 16'h0F00) | 16'd5);
      gpio_in[5] = VEC[i][0];
      tick(3);
      chk($sformatf("R3/R4/R5/R10 vector %0d", i), {15'h0, irq[0]}, {15'h0, VEC[i][2]});
    end
    wr(4'd0, 16'h0);
    gpio_in = '0;
    tick(4);

    // R3 exact latency
    wr(4'd0, 16'h0505);
    gpio_in[5] = 1'b1;
    tick(2);
    chk("R3 not before third edge", {15'h0, irq[0]}, 16'h0);
    tick(1);
    chk("R3 on third edge", {15'h0, irq[0]}, 16'h1);
    rd(4'd8, d); chk("R6 status read", d, 16'h0001);

    // R6 clear
    wr(4'd8, 16'h0001);
    chk("R6 cleared", {15'h0, irq[0]}, 16'h0);
    rd(4'd8, d); chk("R6 status zero", d, 16'h0);

    // R7 edge and clear in same cycle: both edges, falling edge
    wr(4'd0, 16'h0D05);
    gpio_in[5] = 1'b0;
    tick(1);
    tick(1);
    wr(4'd8, 16'h0001);
    chk("R7 edge beats clear", {15'h0, irq[0]}, 16'h1);

    // R8 config rewrite clears pending
    wr(4'd0, 16'h0D05);
    chk("R8 config write clears", {15'h0, irq[0]}, 16'h0);
    rd(4'd8, d); chk("R8 status zero", d, 16'h0);

    // R5 level ignores clear
    wr(4'd0, 16'h0705);
    gpio_in[5] = 1'b1;
    tick(2);
    chk("R5 level high after two edges", {15'h0, irq[0]}, 16'h1);
    wr(4'd8, 16'h00FF);
    chk("R5 level ignores clear", {15'h0, irq[0]}, 16'h1);
    wr(4'd0, 16'h0);

    // R9 out-of-range select reads 0: level-low channel 1 on select 50
    gpio_in = '1;
    wr(4'd1, 16'h0300 | 16'd50);
    tick(3);
    chk("R9 out of range reads 0", {15'h0, irq[1]}, 16'h1);
    wr(4'd1, 16'h0300 | 16'd47);
    tick(1);
    chk("R9 in range bit 47", {15'h0, irq[1]}, 16'h0);
    wr(4'd1, 16'h0);
    gpio_in = '0;
    tick(4);

    // R11 independence: ch2 on bit 0, ch3 on bit 1, rising
    wr(4'd2, 16'h0500);
    wr(4'd3, 16'h0501);
    gpio_in[1] = 1'b1;
    tick(3);
    chk("R11 ch3 fires", {15'h0, irq[3]}, 16'h1);
    chk("R11 ch2 quiet", {15'h0, irq[2]}, 16'h0);
    rd(4'd8, d); chk("R11 status", d, 16'h0008);
    chk("R10 unused channel quiet", {15'h0, irq[7]}, 16'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule